// File: doc/BRIEF.md
# Byte-serial VEX prefix decoder

This block sits in an instruction front end and looks at instruction bytes one at a time. Bytes enter through a valid/ready handshake. A mode input selects 32-bit or 64-bit operation. Bytes that do not begin a vector-extension prefix leave the block unchanged, one output item per input byte. When the block sees escape byte C4h (three-byte form) or C5h (two-byte form), it absorbs the prefix bytes. It then emits a single decoded record in place of those bytes.

The record carries the register-extension bits with their stored inversion undone, and the second-source register number, also un-inverted. It also gives the vector length, the legacy SIMD prefix byte implied by the compact pp code, and the implied opcode map. A reserved-map error flag and the prefix length follow, so a later stage knows where the opcode byte starts.

In 32-bit mode the same two escape bytes also encode two legacy load-pointer instructions. The block therefore inspects the following byte before it commits. If that byte does not have both top bits set, the escape byte and the byte after it leave as two ordinary bytes. Decoding the opcode, ModRM, SIB, displacement and immediate belongs to later stages.

Top module: `vex_prefix_decoder`

## Requirements
- R1: While reset (synchronous, active high) is applied, and on the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: In the idle state, an accepted byte other than C4h or C5h appears on the output one cycle later as a pass-through item. For such an item, out_vex = 0 and out_byte equals the input byte. All record fields (out_rex_r/x/b/w, out_vreg, out_l256, out_simd_pfx, out_map, out_map_err, out_len) are 0.
- R3: C4h followed by bytes P and Q yields exactly one record, and no item is emitted for C4h or P on their own. The record has out_vex = 1, out_byte = C4h and out_len = 3. The register bits are out_rex_r = ~P[7], out_rex_x = ~P[6] and out_rex_b = ~P[5]. The remaining fields come from Q: out_rex_w = Q[7], out_vreg = ~Q[6:3] and out_l256 = Q[2].
- R4: C5h followed by byte P yields exactly one record, and no item is emitted for C5h on its own. The record has out_vex = 1, out_byte = C5h and out_len = 2. It has out_rex_r = ~P[7], out_vreg = ~P[6:3] and out_l256 = P[2]. out_rex_x, out_rex_b and out_rex_w are 0, and out_map = 1 with no error.
- R5: For the three-byte form, the map code P[4:0] values 1, 2 and 3 give out_map 1 (0F), 2 (0F38) and 3 (0F3A) with out_map_err = 0. Every other code gives out_map = 0 and out_map_err = 1.
- R6: The pp code (Q[1:0] in the three-byte form, P[1:0] in the two-byte form) sets out_simd_pfx. Code 0 gives 00h (no prefix), 1 gives 66h, 2 gives F3h and 3 gives F2h.
- R7: With mode64 = 0, if the byte after C4h or C5h has bits 7:6 other than 11b, no record is produced. Instead, two pass-through items follow in order: the escape byte, then that next byte. The block then returns to idle.
- R8: With mode64 = 0, if the byte after C4h or C5h has bits 7:6 equal to 11b, the prefix is decoded as in R3 or R4.
- R9: With mode64 = 1, C4h and C5h always start a prefix, whatever the value of the next byte.
- R10: While out_valid = 1 and out_ready = 0, every output field holds its value and in_ready is 0. No item is lost or repeated.
- R11: Cycles with in_valid = 0, placed anywhere between the bytes of a prefix, do not change the item sequence produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Output item is valid |
| out_ready | input | 1 | Consumer takes the item this cycle |
| out_vex | output | 1 | 1 = decoded prefix record, 0 = pass-through byte |
| out_byte | output | 8 | Pass-through byte, or the escape byte for a record |
| out_rex_r | output | 1 | Register-field extension bit (un-inverted) |
| out_rex_x | output | 1 | Index extension bit (un-inverted) |
| out_rex_b | output | 1 | Base extension bit (un-inverted) |
| out_rex_w | output | 1 | Operand-width / opcode extension bit |
| out_vreg | output | 4 | Second-source register number (un-inverted) |
| out_l256 | output | 1 | 0 = 128-bit, 1 = 256-bit vector length |
| out_simd_pfx | output | 8 | Implied legacy prefix byte: 00h, 66h, F3h or F2h |
| out_map | output | 2 | Implied opcode map: 1 = 0F, 2 = 0F38, 3 = 0F3A, 0 = none |
| out_map_err | output | 1 | Reserved map code seen |
| out_len | output | 2 | Prefix length in bytes (2 or 3), 0 for pass-through |

## Verification
The hardest case to reach from the ports is the 32-bit legacy split when the consumer stalls. One input byte there turns into two output items, and the second item must wait in the block while in_ready is held low. To reach it, the bench repeats the whole set of escape, legacy and plain byte sequences while out_ready follows a pseudo-random pattern. It also inserts idle input cycles between prefix bytes. The scoreboard then confirms the exact item order, and the monitor confirms that stalled outputs hold steady.

// File: rtl/vex_pkg.sv
package vex_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned VREG_W   = 4;
  localparam int unsigned MAPC_W   = 5;
  localparam int unsigned MAP_W    = 2;
  localparam int unsigned LEN_W    = 2;
  localparam logic [BYTE_W-1:0] ESC_LONG  = 8'hC4;
  localparam logic [BYTE_W-1:0] ESC_SHORT = 8'hC5;

  typedef enum logic [MAP_W-1:0] {
    MAP_NONE = 2'd0,
    MAP_0F   = 2'd1,
    MAP_0F38 = 2'd2,
    MAP_0F3A = 2'd3
  } map_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ESC   = 2'd1,
    ST_BODY  = 2'd2,
    ST_FLUSH = 2'd3
  } dec_state_e;

  typedef struct packed {
    logic              r;
    logic              x;
    logic              b;
    logic              w;
    logic [VREG_W-1:0] vreg;
    logic              l256;
    logic [BYTE_W-1:0] simd_pfx;
    map_e              map;
    logic              map_err;
    logic [LEN_W-1:0]  len;
  } vex_rec_t;

  typedef struct packed {
    logic              vex;
    logic [BYTE_W-1:0] data;
    vex_rec_t          rec;
  } out_item_t;

  function automatic logic is_escape(input logic [BYTE_W-1:0] b);
    return (b == ESC_LONG) || (b == ESC_SHORT);
  endfunction

  // Top two bits both set: register-form ModRM in 32-bit code, i.e. VEX
  function automatic logic lookahead_is_vex(input logic [BYTE_W-1:0] b);
    return &b[BYTE_W-1:BYTE_W-2];
  endfunction

  function automatic logic [BYTE_W-1:0] pp_to_prefix(input logic [1:0] pp);
    logic [BYTE_W-1:0] p;
    case (pp)
      2'd1:    p = 8'h66;
      2'd2:    p = 8'hF3;
      2'd3:    p = 8'hF2;
      default: p = 8'h00;
    endcase
    return p;
  endfunction

  function automatic map_e code_to_map(input logic [MAPC_W-1:0] m);
    map_e r;
    case (m)
      5'd1:    r = MAP_0F;
      5'd2:    r = MAP_0F38;
      5'd3:    r = MAP_0F3A;
      default: r = MAP_NONE;
    endcase
    return r;
  endfunction

  function automatic vex_rec_t unpack_long(input logic [BYTE_W-1:0] pa,
                                           input logic [BYTE_W-1:0] pb);
    vex_rec_t v;
    v.r        = ~pa[7];
    v.x        = ~pa[6];
    v.b        = ~pa[5];
    v.map      = code_to_map(pa[4:0]);
    v.map_err  = (v.map == MAP_NONE);
    v.w        = pb[7];
    v.vreg     = ~pb[6:3];
    v.l256     = pb[2];
    v.simd_pfx = pp_to_prefix(pb[1:0]);
    v.len      = LEN_W'(3);
    return v;
  endfunction

  function automatic vex_rec_t unpack_short(input logic [BYTE_W-1:0] pa);
    vex_rec_t v;
    v.r        = ~pa[7];
    v.x        = 1'b0;
    v.b        = 1'b0;
    v.w        = 1'b0;
    v.vreg     = ~pa[6:3];
    v.l256     = pa[2];
    v.simd_pfx = pp_to_prefix(pa[1:0]);
    v.map      = MAP_0F;
    v.map_err  = 1'b0;
    v.len      = LEN_W'(2);
    return v;
  endfunction

endpackage

// File: rtl/vex_field_unpack.sv
module vex_field_unpack
  import vex_pkg::*;
(
  input  logic              long_form,
  input  logic [BYTE_W-1:0] pay_a,
  input  logic [BYTE_W-1:0] pay_b,
  output vex_rec_t          rec
);

  vex_rec_t rec_long;
  vex_rec_t rec_short;

  always_comb begin
    rec_long  = unpack_long(pay_a, pay_b);
    rec_short = unpack_short(pay_a);
    rec       = long_form ? rec_long : rec_short;
  end

endmodule

// File: rtl/vex_seq_fsm.sv
module vex_seq_fsm
  import vex_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode64,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              slot_free,
  output logic              in_ready,
  output logic              load,
  output logic              load_vex,
  output logic [BYTE_W-1:0] load_byte,
  output logic              long_form,
  output logic [BYTE_W-1:0] pay_a,
  output logic [BYTE_W-1:0] pay_b,
  output logic              ev_legacy_split,
  output logic              ev_vex_commit,
  output logic              ev_flush
);

  dec_state_e        st_q, st_d;
  logic              long_q;
  logic [BYTE_W-1:0] pend_q;
  logic              fire;
  logic [BYTE_W-1:0] esc_byte;

  assign in_ready  = (st_q != ST_FLUSH) && slot_free;
  assign fire      = in_valid && in_ready;
  assign esc_byte  = long_q ? ESC_LONG : ESC_SHORT;
  assign long_form = long_q;
  assign pay_a     = (st_q == ST_BODY) ? pend_q : in_byte;
  assign pay_b     = in_byte;

  always_comb begin
    st_d            = st_q;
    load            = 1'b0;
    load_vex        = 1'b0;
    load_byte       = in_byte;
    ev_legacy_split = 1'b0;
    ev_vex_commit   = 1'b0;
    ev_flush        = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (fire) begin
          if (is_escape(in_byte)) begin
            st_d = ST_ESC;
          end else begin
            load = 1'b1;
          end
        end
      end
      ST_ESC: begin
        if (fire) begin
          if (!mode64 && !lookahead_is_vex(in_byte)) begin
            load            = 1'b1;
            load_byte       = esc_byte;
            ev_legacy_split = 1'b1;
            st_d            = ST_FLUSH;
          end else if (long_q) begin
            st_d = ST_BODY;
          end else begin
            load          = 1'b1;
            load_vex      = 1'b1;
            load_byte     = esc_byte;
            ev_vex_commit = 1'b1;
            st_d          = ST_IDLE;
          end
        end
      end
      ST_BODY: begin
        if (fire) begin
          load          = 1'b1;
          load_vex      = 1'b1;
          load_byte     = esc_byte;
          ev_vex_commit = 1'b1;
          st_d          = ST_IDLE;
        end
      end
      ST_FLUSH: begin
        if (slot_free) begin
          load      = 1'b1;
          load_byte = pend_q;
          ev_flush  = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      long_q <= 1'b0;
      pend_q <= '0;
    end else begin
      st_q <= st_d;
      if (fire && (st_q == ST_IDLE)) begin
        long_q <= (in_byte == ESC_LONG);
      end
      if (fire && (st_q == ST_ESC)) begin
        pend_q <= in_byte;
      end
    end
  end

endmodule

// File: rtl/vex_out_stage.sv
module vex_out_stage
  import vex_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  out_item_t item_d,
  input  logic      out_ready,
  output logic      out_valid,
  output logic      slot_free,
  output out_item_t item_q
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      item_q    <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      item_q    <= item_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vex_prefix_decoder.sv
module vex_prefix_decoder
  import vex_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode64,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_vex,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_rex_r,
  output logic              out_rex_x,
  output logic              out_rex_b,
  output logic              out_rex_w,
  output logic [VREG_W-1:0] out_vreg,
  output logic              out_l256,
  output logic [BYTE_W-1:0] out_simd_pfx,
  output logic [MAP_W-1:0]  out_map,
  output logic              out_map_err,
  output logic [LEN_W-1:0]  out_len
);

  logic              slot_free;
  logic              load;
  logic              load_vex;
  logic [BYTE_W-1:0] load_byte;
  logic              long_form;
  logic [BYTE_W-1:0] pay_a;
  logic [BYTE_W-1:0] pay_b;
  logic              ev_legacy_split;
  logic              ev_vex_commit;
  logic              ev_flush;
  vex_rec_t          rec;
  out_item_t         item_d;
  out_item_t         item_q;

  vex_seq_fsm u_fsm (
    .clk             (clk),
    .rst             (rst),
    .mode64          (mode64),
    .in_valid        (in_valid),
    .in_byte         (in_byte),
    .slot_free       (slot_free),
    .in_ready        (in_ready),
    .load            (load),
    .load_vex        (load_vex),
    .load_byte       (load_byte),
    .long_form       (long_form),
    .pay_a           (pay_a),
    .pay_b           (pay_b),
    .ev_legacy_split (ev_legacy_split),
    .ev_vex_commit   (ev_vex_commit),
    .ev_flush        (ev_flush)
  );

  vex_field_unpack u_unpack (
    .long_form (long_form),
    .pay_a     (pay_a),
    .pay_b     (pay_b),
    .rec       (rec)
  );

  always_comb begin
    item_d.vex  = load_vex;
    item_d.data = load_byte;
    item_d.rec  = load_vex ? rec : '0;
  end

  vex_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .item_d    (item_d),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .slot_free (slot_free),
    .item_q    (item_q)
  );

  assign out_vex      = item_q.vex;
  assign out_byte     = item_q.data;
  assign out_rex_r    = item_q.rec.r;
  assign out_rex_x    = item_q.rec.x;
  assign out_rex_b    = item_q.rec.b;
  assign out_rex_w    = item_q.rec.w;
  assign out_vreg     = item_q.rec.vreg;
  assign out_l256     = item_q.rec.l256;
  assign out_simd_pfx = item_q.rec.simd_pfx;
  assign out_map      = item_q.rec.map;
  assign out_map_err  = item_q.rec.map_err;
  assign out_len      = item_q.rec.len;

endmodule

// File: rtl/vex_prefix_decoder_chk.sv
module vex_prefix_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode64,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_vex,
  input logic [7:0] out_byte,
  input logic       out_rex_x,
  input logic       out_rex_b,
  input logic       out_rex_w,
  input logic [7:0] out_simd_pfx,
  input logic [1:0] out_map,
  input logic       out_map_err,
  input logic [1:0] out_len,
  input logic       ev_legacy_split,
  input logic       ev_vex_commit,
  input logic       ev_flush
);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vex) && $stable(out_byte)
                                   && $stable(out_simd_pfx) && $stable(out_len)));

  // R10
  full_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R2
  raw_fields_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_vex) |-> (out_len == 2'd0 && out_map == 2'd0 && !out_map_err
                                 && out_simd_pfx == 8'h00 && !out_rex_w));

  // R3
  record_len_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_vex) |-> (out_len == 2'd2 || out_len == 2'd3));

  // R4
  short_form_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_vex && out_len == 2'd2) |-> (!out_rex_x && !out_rex_b && !out_rex_w
                                                   && out_map == 2'd1 && !out_map_err
                                                   && out_byte == 8'hC5));

  // R5
  map_err_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_vex) |-> (out_map_err == (out_map == 2'd0)));

  // R6
  simd_prefix_set_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_vex) |-> (out_simd_pfx == 8'h00 || out_simd_pfx == 8'h66
                                || out_simd_pfx == 8'hF3 || out_simd_pfx == 8'hF2));

  // R7
  legacy_split_emits_escape_chk: assert property (@(posedge clk) disable iff (rst)
    ev_legacy_split |=> (out_valid && !out_vex && (out_byte == 8'hC4 || out_byte == 8'hC5)));

  // R7
  flush_emits_raw_chk: assert property (@(posedge clk) disable iff (rst)
    ev_flush |=> (out_valid && !out_vex));

  // R9
  no_split_in_long_mode_chk: assert property (@(posedge clk) disable iff (rst)
    ev_legacy_split |-> !mode64);

  // R3
  commit_emits_record_chk: assert property (@(posedge clk) disable iff (rst)
    ev_vex_commit |=> (out_valid && out_vex));

endmodule

bind vex_prefix_decoder vex_prefix_decoder_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .mode64          (mode64),
  .in_ready        (in_ready),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_vex         (out_vex),
  .out_byte        (out_byte),
  .out_rex_x       (out_rex_x),
  .out_rex_b       (out_rex_b),
  .out_rex_w       (out_rex_w),
  .out_simd_pfx    (out_simd_pfx),
  .out_map         (out_map),
  .out_map_err     (out_map_err),
  .out_len         (out_len),
  .ev_legacy_split (ev_legacy_split),
  .ev_vex_commit   (ev_vex_commit),
  .ev_flush        (ev_flush)
);

// File: tb/vex_prefix_decoder_test.sv
module vex_prefix_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int ITEM_W     = 31;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode64 = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_vex;
  logic [7:0] out_byte;
  logic       out_rex_r, out_rex_x, out_rex_b, out_rex_w;
  logic [3:0] out_vreg;
  logic       out_l256;
  logic [7:0] out_simd_pfx;
  logic [1:0] out_map;
  logic       out_map_err;
  logic [1:0] out_len;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int gap    = 0;
  logic bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [ITEM_W-1:0] exp_q[$];
  string             tag_q[$];

  vex_prefix_decoder uut (
    .clk(clk), .rst(rst), .mode64(mode64), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_vex(out_vex), .out_byte(out_byte), .out_rex_r(out_rex_r), .out_rex_x(out_rex_x),
    .out_rex_b(out_rex_b), .out_rex_w(out_rex_w), .out_vreg(out_vreg), .out_l256(out_l256),
    .out_simd_pfx(out_simd_pfx), .out_map(out_map), .out_map_err(out_map_err),
    .out_len(out_len)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  wire [ITEM_W-1:0] got = {out_vex, out_byte, out_rex_r, out_rex_x, out_rex_b, out_rex_w,
                           out_vreg, out_l256, out_simd_pfx, out_map, out_map_err, out_len};

  task automatic check(input string tag, input logic [ITEM_W-1:0] a, input logic [ITEM_W-1:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, a, e);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // expected item builders, written from the requirement text
  function automatic logic [7:0] pfx_of(input int pp);
    if (pp == 1) return 8'h66;
    if (pp == 2) return 8'hF3;
    if (pp == 3) return 8'hF2;
    return 8'h00;
  endfunction

  function automatic logic [ITEM_W-1:0] exp_raw(input logic [7:0] b);
    return {1'b1 ^ 1'b1, b, 22'd0};
  endfunction

  function automatic logic [ITEM_W-1:0] exp_long(input logic [7:0] p, input logic [7:0] q);
    int m;
    logic [1:0] mp;
    logic err;
    logic [3:0] vr;
    m  = int'(p & 8'h1F);
    mp = (m >= 1 && m <= 3) ? 2'(m) : 2'd0;
    err = !(m >= 1 && m <= 3);
    vr = 4'(15 - int'(q[6:3]));
    return {1'b1, 8'hC4, !p[7], !p[6], !p[5], q[7], vr, q[2], pfx_of(int'(q[1:0])),
            mp, err, 2'd3};
  endfunction

  function automatic logic [ITEM_W-1:0] exp_short(input logic [7:0] p);
    logic [3:0] vr;
    vr = 4'(15 - int'(p[6:3]));
    return {1'b1, 8'hC5, !p[7], 1'b0, 1'b0, 1'b0, vr, p[2], pfx_of(int'(p[1:0])),
            2'd1, 1'b0, 2'd2};
  endfunction

  task automatic push(input logic [ITEM_W-1:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h00;
    repeat (gap) @(negedge clk);
  endtask

  task automatic seq_raw(input logic [7:0] b, input string tag);
    push(exp_raw(b), tag);
    send(b);
  endtask

  task automatic seq_long(input logic [7:0] p, input logic [7:0] q, input string tag);
    push(exp_long(p, q), tag);
    send(8'hC4); send(p); send(q);
  endtask

  task automatic seq_short(input logic [7:0] p, input string tag);
    push(exp_short(p), tag);
    send(8'hC5); send(p);
  endtask

  task automatic seq_legacy(input logic [7:0] esc, input logic [7:0] nb);
    push(exp_raw(esc), "R7 escape");
    push(exp_raw(nb), "R7 next");
    send(esc); send(nb);
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10: %0d items missing, expected 0", exp_q.size());
    end
  endtask

  task automatic run_suite();
    mode64 = 1'b1;
    // R2
    seq_raw(8'h90, "R2"); seq_raw(8'h0F, "R2"); seq_raw(8'h62, "R2"); seq_raw(8'hC3, "R2");
    // R3 register bits and vreg/W/L
    seq_long(8'hE2, 8'h7D, "R3");
    seq_long(8'h01, 8'h80, "R3");
    seq_long(8'h43, 8'hB4, "R3");
    // R5 map codes
    for (int m = 0; m < 8; m++) seq_long(8'hE0 | 8'(m), 8'h78, "R5");
    seq_long(8'hFF, 8'h78, "R5");
    // R6 pp codes both forms
    for (int pp = 0; pp < 4; pp++) seq_long(8'hE1, 8'h78 | 8'(pp), "R6");
    for (int pp = 0; pp < 4; pp++) seq_short(8'hF8 | 8'(pp), "R6");
    // R4 short form, vreg sweep
    for (int v = 0; v < 16; v += 5) seq_short(8'h84 | 8'(v << 3), "R4");
    seq_short(8'h7F, "R4");
    // R9 long mode with low-top-bit next byte
    seq_long(8'h3F, 8'h00, "R9");
    seq_short(8'h45, "R9");
    // R7 / R8 in 32-bit mode
    mode64 = 1'b0;
    seq_legacy(8'hC4, 8'h3F);
    seq_raw(8'h90, "R7 idle after");
    seq_legacy(8'hC5, 8'h80);
    seq_legacy(8'hC4, 8'h45);
    seq_short(8'hF9, "R8");
    seq_long(8'hE2, 8'h79, "R8");
    seq_long(8'hC1, 8'h05, "R8");
    seq_raw(8'hC3, "R8 idle after");
    mode64 = 1'b1;
  endtask

  // back-pressure pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_on ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  logic              stalled = 1'b0;
  logic [ITEM_W-1:0] held;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (stalled) begin
        check("R10 hold", got, held);
        checks++;
        if (!out_valid) begin
          fails++;
          $display("FAIL R10 valid dropped: got %b expected 1", out_valid);
        end
      end
      stalled = out_valid && !out_ready;
      held    = got;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R3 extra item: got %h expected none", got);
        end else begin
          check(tag_q.pop_front(), got, exp_q.pop_front());
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 reset valid", {30'd0, out_valid}, 31'd0);
    check("R1 reset ready", {30'd0, in_ready}, 31'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after valid", {30'd0, out_valid}, 31'd0);
    check("R1 after ready", {30'd0, in_ready}, 31'd1);

    gap = 0; bp_on = 1'b0;
    run_suite();
    drain();
    // R11 idle input cycles between prefix bytes
    gap = 2;
    run_suite();
    drain();
    // R10 consumer stalls
    gap = 0; bp_on = 1'b1;
    run_suite();
    drain();
    gap = 1;
    run_suite();
    drain();
    bp_on = 1'b0;
    repeat (4) @(negedge clk);
    report();
  end

endmodule